// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures an FPGA through its slave-serial configuration port from a stream of payload bytes. A start request with an image index runs the whole sequence. It switches configuration power on and waits a fixed settling interval. It then drives the program-request line low for a set time and waits for the device's init line to rise. After that it shifts each payload byte out most significant bit first under a generated configuration clock. Once the final byte has gone out, it keeps clocking until the device reports done.

Each wait has its own bound. If init or done fails to arrive in time, the block ends the run with a timeout status. The block remembers the index of the image it last loaded successfully. A later request for that same index completes at once, with no power wait and no program pulse. A failed or aborted load forgets the remembered index, so the next request always reloads. The upstream byte source can signal an error, which ends streaming early and moves the block straight to the done wait.

Top module: `cfg_loader`

## Requirements
- R1: After reset, pwr_on_o=0, prog_no=1, cclk_o=0, din_o=0, busy_o=0, ok_o=0, tmo_o=0 and byte_ready_o=0. Whenever the block is idle, cclk_o and din_o are low.
- R2: When start_i is sampled high while idle and no skip applies, busy_o and pwr_on_o are high from the next cycle. pwr_on_o then stays high. prog_no stays high for exactly PWR_CYC cycles, then low for exactly PROG_CYC cycles. prog_no is never low while pwr_on_o is low.
- R3: din_o is low from the start of a load until streaming begins, including the whole time prog_no is low.
- R4: Each accepted byte goes out bit 7 first. Each bit is set on din_o while cclk_o is low for CLK_HALF cycles, then cclk_o is high for CLK_HALF cycles, and din_o does not change while cclk_o is high. The bits captured on the rising edges of cclk_o reproduce the accepted bytes in order.
- R5: Streaming starts only after init_i is seen high following the program pulse. If init_i stays low for INIT_TMO cycles, busy_o falls with tmo_o=1 and no cclk_o pulse is produced. The load is then PWR_CYC+PROG_CYC+INIT_TMO cycles long.
- R6: After the byte flagged with byte_last_i has been shifted, cclk_o keeps pulsing with din_o low until done_i is high. busy_o then falls with ok_o=1.
- R7: If done_i stays low for DONE_TMO cycles of the done wait, busy_o falls with tmo_o=1 and ok_o=0.
- R8: A start whose idx_i equals the index of the last successful load gives ok_o=1 on the next cycle. busy_o stays low and prog_no never pulses.
- R9: A start with a different index, or any start after a failed load, runs the full sequence, including the program pulse.
- R10: byte_err_i high while byte_ready_o is high ends streaming. No further byte is accepted, and the block enters the done wait.
- R11: ok_o and tmo_o are never high together. Both clear when a load starts and hold their value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, sampled while idle |
| idx_i | input | IDX_W | Image index of the request |
| byte_data_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_last_i | input | 1 | Marks the final payload byte |
| byte_err_i | input | 1 | Upstream source error, aborts streaming |
| byte_ready_o | output | 1 | Block accepts a payload byte |
| init_i | input | 1 | Device init line (pulled up) |
| done_i | input | 1 | Device done line (pulled up) |
| pwr_on_o | output | 1 | Configuration power enable |
| prog_no | output | 1 | Active-low program request |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration serial data |
| busy_o | output | 1 | Load sequence in progress |
| ok_o | output | 1 | Last request ended with the image in place |
| tmo_o | output | 1 | Last request ended on an init or done timeout |

## Verification
A sequencer stuck in the wrong phase shows within one cycle as a program pulse or power wait of the wrong length, since both are counted to the exact cycle at prog_no. A shifter fault shows by the eighth rising edge of cclk_o as a wrong captured byte, or as din_o moving while cclk_o is high. A stale or uncleared remembered index shows on the cycle after start_i: busy_o stays low where a reload was due, or a program pulse appears where a skip was due. An abort that fails to stop the stream shows as a second payload byte arriving where only done-wait zeros belong.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_PROG,
    ST_INIT,
    ST_SHIFT,
    ST_DONE
  } cfg_state_e;
endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       pulse_i,
  output logic       act_o,
  output logic       cclk_o,
  output logic       din_o
);
  localparam int HW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [HW-1:0] HC_END = HW'(CLK_HALF - 1);

  logic [6:0]    sreg_q;
  logic [2:0]    bcnt_q;
  logic [HW-1:0] hc_q;
  logic          act_q, cclk_q, din_q;
  logic          half_end;

  assign half_end = (hc_q == HC_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      bcnt_q <= '0;
      hc_q   <= '0;
      act_q  <= 1'b0;
      cclk_q <= 1'b0;
      din_q  <= 1'b0;
    end else if (load_i) begin
      sreg_q <= data_i[6:0];
      din_q  <= data_i[7];
      bcnt_q <= 3'd7;
      hc_q   <= '0;
      cclk_q <= 1'b0;
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (!half_end) begin
        hc_q <= hc_q + 1'b1;
      end else begin
        hc_q <= '0;
        if (!cclk_q) begin
          cclk_q <= 1'b1;
        end else begin
          cclk_q <= 1'b0;
          if (bcnt_q == 3'd0) begin
            act_q <= 1'b0;
            din_q <= 1'b0;
          end else begin
            bcnt_q <= bcnt_q - 1'b1;
            din_q  <= sreg_q[6];
            sreg_q <= {sreg_q[5:0], 1'b0};
          end
        end
      end
    end else if (pulse_i) begin
      // free-running clock with data low while waiting for done
      din_q <= 1'b0;
      if (!half_end) begin
        hc_q <= hc_q + 1'b1;
      end else begin
        hc_q   <= '0;
        cclk_q <= ~cclk_q;
      end
    end else begin
      hc_q   <= '0;
      cclk_q <= 1'b0;
      din_q  <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign cclk_o = cclk_q;
  assign din_o  = din_q;

  AST_DIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> $stable(din_o)); // R4
  AST_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !act_o); // R4
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int IDX_W    = 2,
  parameter int CLK_HALF = 2,
  parameter int PWR_CYC  = 10_000_000,
  parameter int PROG_CYC = 200,
  parameter int INIT_TMO = 200_000,
  parameter int DONE_TMO = 2_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  input  logic             byte_last_i,
  input  logic             byte_err_i,
  output logic             byte_ready_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             pwr_on_o,
  output logic             prog_no,
  output logic             cclk_o,
  output logic             din_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             tmo_o
);
  localparam int M1      = (PWR_CYC > PROG_CYC) ? PWR_CYC : PROG_CYC;
  localparam int M2      = (INIT_TMO > DONE_TMO) ? INIT_TMO : DONE_TMO;
  localparam int TMR_MAX = (M1 > M2) ? M1 : M2;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  cfg_state_e       state_q, state_d;
  logic             pwr_q, ok_q, tmo_q, last_q, ld_vld_q;
  logic [IDX_W-1:0] ld_idx_q, req_idx_q;
  logic             tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             sh_act, ready, accept, abort, match;

  assign match  = ld_vld_q && (idx_i == ld_idx_q);
  assign ready  = (state_q == ST_SHIFT) && !sh_act && !last_q;
  assign accept = ready && byte_valid_i && !byte_err_i;
  assign abort  = ready && byte_err_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i && !match) state_d = ST_PWR;
      ST_PWR:   if (tmr_zero) state_d = ST_PROG;
      ST_PROG:  if (tmr_zero) state_d = ST_INIT;
      ST_INIT:  if (init_i) state_d = ST_SHIFT;
                else if (tmr_zero) state_d = ST_IDLE;
      ST_SHIFT: if (abort || (last_q && !sh_act)) state_d = ST_DONE;
      ST_DONE:  if (done_i || tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_PWR:  tmr_val = TMR_W'(PWR_CYC - 1);
      ST_PROG: tmr_val = TMR_W'(PROG_CYC - 1);
      ST_INIT: tmr_val = TMR_W'(INIT_TMO - 1);
      ST_DONE: tmr_val = TMR_W'(DONE_TMO - 1);
      default: tmr_val = '0;
    endcase
  end

  cfg_timer #(.W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  cfg_shifter #(.CLK_HALF(CLK_HALF)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .data_i  (byte_data_i),
    .pulse_i (state_q == ST_DONE),
    .act_o   (sh_act),
    .cclk_o  (cclk_o),
    .din_o   (din_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pwr_q     <= 1'b0;
      ok_q      <= 1'b0;
      tmo_q     <= 1'b0;
      last_q    <= 1'b0;
      ld_vld_q  <= 1'b0;
      ld_idx_q  <= '0;
      req_idx_q <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ok_q  <= match;
          tmo_q <= 1'b0;
          if (!match) begin
            pwr_q     <= 1'b1;
            ld_vld_q  <= 1'b0;  // program pulse wipes the resident image
            req_idx_q <= idx_i;
            last_q    <= 1'b0;
          end
        end
        ST_INIT: if (!init_i && tmr_zero) tmo_q <= 1'b1;
        ST_SHIFT: if (accept && byte_last_i) last_q <= 1'b1;
        ST_DONE: if (done_i) begin
          ok_q     <= 1'b1;
          ld_idx_q <= req_idx_q;
          ld_vld_q <= 1'b1;
        end else if (tmr_zero) begin
          tmo_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign byte_ready_o = ready;
  assign pwr_on_o     = pwr_q;
  assign prog_no      = (state_q != ST_PROG);
  assign busy_o       = (state_q != ST_IDLE);
  assign ok_o         = ok_q;
  assign tmo_o        = tmo_q;

  AST_PROG_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> pwr_on_o); // R2
  AST_DIN_LOW_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_PWR, ST_PROG, ST_INIT}) |-> !din_o); // R3
  AST_INIT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT && !init_i) |=> (state_q != ST_SHIFT)); // R5
  AST_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && match) |=> (!busy_o && ok_o)); // R8
  AST_ABORT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !byte_ready_o); // R10
  AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && tmo_o)); // R11
endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int IDX_W = 2, HALF = 2, PWR = 20, PROG = 8, ITMO = 40, DTMO = 64;

  // {idx[15:14], nb[13:11], init_ok[10], done_ok[9], err_at[8:6], exp_ok[5], exp_tmo[4], skip[3], kind[1:0]}
  // kind: 0 full load, 1 init timeout, 2 done timeout, 3 source error
  localparam int NV = 9;
  localparam logic [15:0] TBL [0:NV-1] = '{
    {2'd1, 3'd4, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd1, 3'd4, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0},
    {2'd2, 3'd3, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd3, 3'd2, 1'b0, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {2'd3, 3'd2, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd0, 3'd2, 1'b1, 1'b0, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    {2'd0, 3'd4, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3},
    {2'd0, 3'd1, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {2'd0, 3'd1, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0] idx = '0;
  logic [7:0] bdata = '0;
  logic bvalid = 1'b0, blast = 1'b0, berr = 1'b0;
  logic init_q = 1'b0, done_q = 1'b0;
  logic ready, pwr_on, prog_n, cclk, din, busy, ok, tmo;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cfg_loader #(.IDX_W(IDX_W), .CLK_HALF(HALF), .PWR_CYC(PWR), .PROG_CYC(PROG),
               .INIT_TMO(ITMO), .DONE_TMO(DTMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idx_i(idx),
    .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_last_i(blast), .byte_err_i(berr),
    .byte_ready_o(ready), .init_i(init_q), .done_i(done_q),
    .pwr_on_o(pwr_on), .prog_no(prog_n), .cclk_o(cclk), .din_o(din),
    .busy_o(busy), .ok_o(ok), .tmo_o(tmo));

  function automatic logic [7:0] gen(input int k, input logic [IDX_W-1:0] ix);
    logic [7:0] kk = 8'(k * 29);
    return 8'h5A ^ kk ^ {2'b00, ix, 4'h0};
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // device model and port monitor
  int dly = 3, bits = 0, done_at = 0, pwr_cnt = 0, prog_cnt = 0, busy_cnt = 0, prog_falls = 0;
  bit init_en = 1'b0, done_en = 1'b0, prog_seen = 1'b0, cclk_p = 1'b0, prog_p = 1'b1;
  logic [7:0] rx_sh = '0;
  logic [7:0] rx [0:7];

  always @(negedge clk) begin
    if (!prog_n) begin
      init_q <= 1'b0; done_q <= 1'b0; dly <= 0;
    end else if (dly < 3) dly <= dly + 1;
    else if (init_en) init_q <= 1'b1;
    if (prog_n && done_en && bits >= done_at && done_at > 0) done_q <= 1'b1;
    if (cclk && !cclk_p) begin
      rx_sh = {rx_sh[6:0], din};
      bits++;
      if (bits % 8 == 0 && bits <= 64) rx[bits/8 - 1] = rx_sh;
    end
    if (busy) busy_cnt++;
    if (!prog_n) begin prog_cnt++; prog_seen = 1'b1; end
    else if (busy && !prog_seen) pwr_cnt++;
    if (!prog_n && prog_p) prog_falls++;
    cclk_p = cclk;
    prog_p = prog_n;
  end

  // byte source
  int src_k = 0, src_n = 0, src_err = 7;
  bit src_en = 1'b0, acc_q = 1'b0;
  logic [IDX_W-1:0] src_idx = '0;
  always @(negedge clk) begin
    if (acc_q) src_k++;
    if (src_en && src_k == src_err) begin
      berr = 1'b1; bvalid = 1'b0; blast = 1'b0;
    end else if (src_en && src_k < src_n) begin
      berr = 1'b0; bvalid = 1'b1; bdata = gen(src_k, src_idx); blast = (src_k == src_n - 1);
    end else begin
      berr = 1'b0; bvalid = 1'b0; blast = 1'b0;
    end
    acc_q = bvalid && ready && !berr;
  end

  task automatic run_entry(input logic [15:0] v);
    logic [IDX_W-1:0] ix = v[15:14];
    int nb = int'(v[13:11]);
    bit skip = v[3];
    int kind = int'(v[1:0]);
    int guard = 0;
    int falls0;
    for (int i = 0; i < 8; i++) rx[i] = '0;
    bits = 0; pwr_cnt = 0; prog_cnt = 0; busy_cnt = 0; prog_seen = 1'b0;
    falls0 = prog_falls;
    init_en = v[10]; done_en = v[9];
    done_at = nb * 8 + 3;
    src_idx = ix; src_n = nb; src_err = int'(v[8:6]); src_k = 0; src_en = 1'b1;
    @(negedge clk); idx = ix; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (skip) begin
      chk(!busy && ok, "R8 skip ok next cycle", {busy, ok}, 1);
    end else begin
      chk(busy && pwr_on && !ok && !tmo, "R11 R2 load start status", {busy, pwr_on, ok, tmo}, 12);
    end
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R2 load ends", guard, 0);
    src_en = 1'b0;
    chk(ok == v[5] && tmo == v[4], "R11 final status", {ok, tmo}, {v[5], v[4]});
    if (skip) begin
      chk(prog_falls == falls0 && busy_cnt == 0, "R8 no program pulse", prog_falls - falls0, 0);
    end else begin
      chk(prog_falls == falls0 + 1, "R9 program pulse on reload", prog_falls - falls0, 1);
      chk(pwr_cnt == PWR, "R2 power wait length", pwr_cnt, PWR);
      chk(prog_cnt == PROG, "R2 program low length", prog_cnt, PROG);
      case (kind)
        0: begin
          for (int i = 0; i < nb; i++)
            chk(rx[i] == gen(i, ix), "R4 byte msb first", rx[i], gen(i, ix));
          chk(bits >= nb * 8 + 3, "R6 clocks until done", bits, nb * 8 + 3);
        end
        1: begin
          chk(bits == 0, "R5 no clock without init", bits, 0);
          chk(busy_cnt == PWR + PROG + ITMO, "R5 init timeout length", busy_cnt, PWR + PROG + ITMO);
        end
        2: begin
          for (int i = 0; i < nb; i++)
            chk(rx[i] == gen(i, ix), "R7 bytes before done timeout", rx[i], gen(i, ix));
          chk(bits > nb * 8 && rx[nb] == 8'h00, "R7 clocks with din low", bits, nb * 8 + 8);
        end
        default: begin
          chk(rx[0] == gen(0, ix), "R10 byte before error", rx[0], gen(0, ix));
          chk(rx[1] == 8'h00, "R10 no byte after error", rx[1], 0);
        end
      endcase
    end
    repeat (3) @(negedge clk);
    chk(!cclk && !din && !ready, "R1 idle outputs low", {cclk, din, ready}, 0);
    chk(ok == v[5] && tmo == v[4], "R11 status held", {ok, tmo}, {v[5], v[4]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pwr_on && prog_n && !cclk && !din && !busy && !ok && !tmo && !ready,
        "R1 reset state", {pwr_on, prog_n, cclk, din, busy, ok, tmo, ready}, 8'h40);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pwr_on && prog_n && !busy && !ok && !tmo, "R1 idle after reset",
        {pwr_on, prog_n, busy, ok, tmo}, 5'h08);
    for (int e = 0; e < NV; e++) run_entry(TBL[e]);
    // start while busy is ignored: a second start mid-load does not restart the power wait
    bits = 0; pwr_cnt = 0; prog_cnt = 0; busy_cnt = 0; prog_seen = 1'b0;
    init_en = 1'b1; done_en = 1'b1; done_at = 11; src_idx = 2'd2; src_n = 1; src_err = 7;
    src_k = 0; src_en = 1'b1;
    @(negedge clk); idx = 2'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    src_en = 1'b0;
    chk(pwr_cnt == PWR && ok, "R2 start ignored while busy", pwr_cnt, PWR);
    chk(rx[0] == gen(0, 2'd2), "R9 reload other index", rx[0], gen(0, 2'd2));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule